// File: doc/BRIEF.md
# Shared Event Word with Per-Core Wait

This block holds one 32-bit event word shared by a group of small coprocessor cores. The lower 24 bits are software events. Any core can raise them through a write-one set register and drop them through a write-one clear register. The upper 8 bits are not stored. They mirror a byte of level flags that arrive from FIFOs elsewhere in the design.

Each core owns a private sensitivity mask. When a core reads its wait register, it stalls until its mask and the event word share at least one set bit. The read then completes and returns the whole event word, not only the bits that matched. Cores use this to sleep until a peer, or a FIFO, signals them.

Top module: `evt_hub`

## Requirements
- R1: The event word `evt_word` is 32 bits wide. Bits 31:24 equal `fifo_flags` in the same cycle. Set and clear writes to bits 31:24 never change them.
- R2: A set write sets each bit `b` in 23:0 for which `set_data` holds a 1. The bit reads as 1 on `evt_word` from the cycle after the write.
- R3: A clear write clears each bit `b` in 23:0 for which `clr_data` holds a 1. The bit reads as 0 from the cycle after the write.
- R4: Each core's mask is loaded from its `mask_data` slice when its `mask_we` bit is high, and it takes effect the cycle after. A mask write by one core leaves every other core's mask unchanged.
- R5: While a core holds `wait_req` and the AND of its mask with `evt_word` is zero, `wait_ready` for that core stays 0 and its `wait_data` slice reads 0.
- R6: When `wait_ready` is 1, the core's `wait_data` slice equals the full unmasked `evt_word`, including the flag byte.
- R7: If a set and a clear hit the same bit in the same cycle, the bit ends at 1.
- R8: Set writes from several cores in one cycle are ORed together. Clear writes from several cores in one cycle are also ORed together.
- R9: While `rst_n` is low at a clock edge, the stored bits 23:0 and every mask become 0.
- R10: A wait whose condition already holds raises `wait_ready` in the same cycle that `wait_req` is first seen. There is no stall.

Core `c` uses slice `[32*c+31 : 32*c]` of every per-core bus. Its control bit is bit `c` of each enable vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_flags | input | 8 | FIFO level flags shown in bits 31:24 |
| set_we | input | NUM_CORES | Per-core set-register write strobe |
| set_data | input | 32*NUM_CORES | Per-core write-one-to-set data |
| clr_we | input | NUM_CORES | Per-core clear-register write strobe |
| clr_data | input | 32*NUM_CORES | Per-core write-one-to-clear data |
| mask_we | input | NUM_CORES | Per-core mask write strobe |
| mask_data | input | 32*NUM_CORES | Per-core new mask value |
| wait_req | input | NUM_CORES | Core is reading its wait register |
| wait_ready | output | NUM_CORES | Wait read completes this cycle |
| wait_data | output | 32*NUM_CORES | Event word returned to a released core |
| evt_word | output | 32 | Current shared event word |

## Verification
The hardest case to reach is a core that has stalled and is then released by a write from a different core. The release must come one cycle after that write, and the word returned must include unmasked bits and flag bits.

Random traffic seldom produces this, because sparse random sets usually satisfy a wait at once. Directed sequences therefore park one core on a single event bit while other events and flags are nonzero, and then let a peer set that bit. Same-cycle set/clear collisions and multi-core ORing are forced the same way. These directed sequences are mixed with seeded random traffic.

// File: rtl/evt_pkg.sv
// Package: shared constants and the event update rule.
// Assumes one event word per hub, with the flag byte at the top.
package evt_pkg;
    localparam int EVT_W_DEF  = 32;
    localparam int FLAG_W_DEF = 8;

    // Next value of the software event bits; set wins over clear.
    function automatic logic [EVT_W_DEF-1:0] evt_next(
        input logic [EVT_W_DEF-1:0] cur,
        input logic [EVT_W_DEF-1:0] set_bits,
        input logic [EVT_W_DEF-1:0] clr_bits
    );
        return (cur & ~clr_bits) | set_bits;
    endfunction
endpackage

// File: rtl/evt_merge.sv
// Module: ORs the write-one data of all cores whose strobe is high.
// Assumes the data bus is NUM_CORES slices of W bits, core 0 lowest.
module evt_merge #(
    parameter int NUM_CORES = 4,
    parameter int W         = 32
) (
    input  logic [NUM_CORES-1:0]   we,
    input  logic [NUM_CORES*W-1:0] data,
    output logic [W-1:0]           merged
);
    logic [W-1:0] acc [NUM_CORES+1];

    assign acc[0] = '0;

    // Accumulate the enabled slices in a chain of OR gates.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_or
        assign acc[c+1] = acc[c] | (we[c] ? data[c*W +: W] : '0);
    end

    assign merged = acc[NUM_CORES];
endmodule

// File: rtl/evt_store.sv
// Module: holds the settable low part of the event word.
// Assumes the set and clear inputs are already merged over all cores.
module evt_store
    import evt_pkg::*;
#(
    parameter int W      = 32,
    parameter int SOFT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      set_any,
    input  logic [W-1:0]      clr_any,
    output logic [SOFT_W-1:0] soft_q
);
    logic [W-1:0] next_full;
    logic [W-1:0] cur_full;
    logic         unused_hi;

    assign cur_full  = {{(W-SOFT_W){1'b0}}, soft_q};
    assign next_full = evt_next(cur_full, set_any, clr_any);
    assign unused_hi = ^next_full[W-1:SOFT_W];

    // Register the stored bits; synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_q <= '0;
        else        soft_q <= next_full[SOFT_W-1:0];
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((soft_q & $past(set_any[SOFT_W-1:0])) == $past(set_any[SOFT_W-1:0]))); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((soft_q & $past(clr_any[SOFT_W-1:0] & ~set_any[SOFT_W-1:0])) == '0)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_any[0] && clr_any[0])) |=> soft_q[0]); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_any[SOFT_W-1:0] == '0) && (clr_any[SOFT_W-1:0] == '0)) |=> $stable(soft_q)); // R2
endmodule

// File: rtl/evt_waiter.sv
// Module: one core's sensitivity mask and wait-read handshake.
// Assumes the core holds wait_req until wait_ready is returned.
module evt_waiter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_word,
    input  logic         mask_we,
    input  logic [W-1:0] mask_data,
    input  logic         wait_req,
    output logic         wait_ready,
    output logic [W-1:0] wait_data
);
    logic [W-1:0] mask_q;
    logic         hit;

    // Load the private mask on a write; synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end

    // Release the wait when any masked event is present.
    always_comb begin
        hit        = |(mask_q & evt_word);
        wait_ready = wait_req && hit;
        wait_data  = wait_ready ? evt_word : '0;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_data))); // R4
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q)); // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        wait_ready |-> wait_req); // R5
endmodule

// File: rtl/evt_hub.sv
// Module: top of the shared event word with per-core wait registers.
// Assumes the FIFO flags are synchronous to clk.
module evt_hub
    import evt_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int EVT_W     = EVT_W_DEF,
    parameter int FLAG_W    = FLAG_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [FLAG_W-1:0]          fifo_flags,
    input  logic [NUM_CORES-1:0]       set_we,
    input  logic [NUM_CORES*EVT_W-1:0] set_data,
    input  logic [NUM_CORES-1:0]       clr_we,
    input  logic [NUM_CORES*EVT_W-1:0] clr_data,
    input  logic [NUM_CORES-1:0]       mask_we,
    input  logic [NUM_CORES*EVT_W-1:0] mask_data,
    input  logic [NUM_CORES-1:0]       wait_req,
    output logic [NUM_CORES-1:0]       wait_ready,
    output logic [NUM_CORES*EVT_W-1:0] wait_data,
    output logic [EVT_W-1:0]           evt_word
);
    localparam int SOFT_W = EVT_W - FLAG_W;

    logic [EVT_W-1:0]  set_any;
    logic [EVT_W-1:0]  clr_any;
    logic [SOFT_W-1:0] soft_q;

    // Combine set strobes from all cores.
    evt_merge #(.NUM_CORES(NUM_CORES), .W(EVT_W)) u_set_merge (
        .we(set_we), .data(set_data), .merged(set_any)
    );

    // Combine clear strobes from all cores.
    evt_merge #(.NUM_CORES(NUM_CORES), .W(EVT_W)) u_clr_merge (
        .we(clr_we), .data(clr_data), .merged(clr_any)
    );

    // Storage for the writable event bits.
    evt_store #(.W(EVT_W), .SOFT_W(SOFT_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .set_any(set_any), .clr_any(clr_any), .soft_q(soft_q)
    );

    assign evt_word = {fifo_flags, soft_q};

    // One mask and wait port per core.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        evt_waiter #(.W(EVT_W)) u_waiter (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_word  (evt_word),
            .mask_we   (mask_we[c]),
            .mask_data (mask_data[c*EVT_W +: EVT_W]),
            .wait_req  (wait_req[c]),
            .wait_ready(wait_ready[c]),
            .wait_data (wait_data[c*EVT_W +: EVT_W])
        );
    end

    AST_FLAG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_word[EVT_W-1:SOFT_W] == fifo_flags); // R1
    AST_RELEASE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wait_ready[0] |-> (wait_data[EVT_W-1:0] == evt_word)); // R6
endmodule

// File: tb/evt_hub_bench.sv
module evt_hub_bench;
    localparam int N = 4;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [7:0]     fifo_flags;
    logic [N-1:0]   set_we, clr_we, mask_we, wait_req;
    logic [N*W-1:0] set_data, clr_data, mask_data;
    logic [N-1:0]   wait_ready;
    logic [N*W-1:0] wait_data;
    logic [W-1:0]   evt_word;

    evt_hub #(.NUM_CORES(N)) u_evt_hub (
        .clk(clk), .rst_n(rst_n), .fifo_flags(fifo_flags),
        .set_we(set_we), .set_data(set_data),
        .clr_we(clr_we), .clr_data(clr_data),
        .mask_we(mask_we), .mask_data(mask_data),
        .wait_req(wait_req), .wait_ready(wait_ready),
        .wait_data(wait_data), .evt_word(evt_word)
    );

    always #5 clk = ~clk;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;
    logic [23:0] m_soft;
    logic [W-1:0] m_mask [N];

    function automatic logic [W-1:0] exp_word();
        return {fifo_flags, m_soft};
    endfunction

    function automatic logic exp_ready(input int c);
        return wait_req[c] && ((m_mask[c] & exp_word()) != '0);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle();
        set_we = '0; clr_we = '0; mask_we = '0; wait_req = '0;
        set_data = '0; clr_data = '0; mask_data = '0;
    endtask

    // Compare all outputs against the model before the edge.
    task automatic check_all(input string tag);
        check({tag, " R1 word"}, evt_word, exp_word());
        for (int c = 0; c < N; c++) begin
            check({tag, " R5 ready"}, {31'b0, wait_ready[c]}, {31'b0, exp_ready(c)});
            check({tag, " R6 data"}, wait_data[c*W +: W], exp_ready(c) ? exp_word() : '0);
        end
    endtask

    // Advance one clock and update the model; inputs change at negedge.
    task automatic step();
        logic [W-1:0] s, k;
        s = '0; k = '0;
        for (int c = 0; c < N; c++) begin
            if (set_we[c]) s |= set_data[c*W +: W];
            if (clr_we[c]) k |= clr_data[c*W +: W];
        end
        @(posedge clk);
        if (!rst_n) begin
            m_soft = '0;
            for (int c = 0; c < N; c++) m_mask[c] = '0;
        end else begin
            m_soft = (m_soft & ~k[23:0]) | s[23:0];
            for (int c = 0; c < N; c++)
                if (mask_we[c]) m_mask[c] = mask_data[c*W +: W];
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog R1 got=hung exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_soft = 'x;
        for (int c = 0; c < N; c++) m_mask[c] = 'x;
        idle();
        fifo_flags = 8'h00;
        rst_n = 1'b0;
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;

        // R9: reset state, with an all-ones wait request still stalled.
        wait_req = '1;
        #1;
        check("R9 reset word", evt_word, 32'h0);
        check("R9 reset masks", {28'b0, wait_ready}, 32'h0);
        idle();

        // R1: writes to the flag byte are ignored; the flags pass through.
        fifo_flags = 8'h00;
        set_we[0] = 1'b1;
        set_data[31:0] = 32'hFF00_0001;
        step();
        idle();
        #1;
        check("R1 top byte ignores set", evt_word, 32'h0000_0001);
        fifo_flags = 8'hA5;
        clr_we[1] = 1'b1;
        clr_data[63:32] = 32'hFF00_0000;
        #1;
        check("R1 flags same cycle", evt_word, 32'hA500_0001);
        step();
        idle();
        #1;
        check("R1 top byte ignores clear", evt_word, 32'hA500_0001);

        // R8: sets from two cores in one cycle are ORed.
        set_we = 4'b1010;
        set_data[63:32] = 32'h0000_0100;
        set_data[127:96] = 32'h0000_8000;
        step();
        idle();
        #1;
        check("R8 OR of sets", evt_word, 32'hA500_8101);

        // R7: set and clear of the same bit in one cycle leaves it set.
        set_we[2] = 1'b1;
        set_data[95:64] = 32'h0000_0010;
        clr_we[3] = 1'b1;
        clr_data[127:96] = 32'h0000_8010;
        step();
        idle();
        #1;
        check("R7 set beats clear", evt_word, 32'hA500_0111);

        // R3 and R8: clears from two cores are ORed.
        clr_we = 4'b0011;
        clr_data[31:0] = 32'h0000_0001;
        clr_data[63:32] = 32'h0000_0100;
        step();
        idle();
        #1;
        check("R3 OR of clears", evt_word, 32'hA500_0010);

        // R4: core 0 mask on bit 5; core 1 mask untouched, so it stays stalled.
        mask_we[0] = 1'b1;
        mask_data[31:0] = 32'h0000_0020;
        wait_req[0] = 1'b1;
        #1;
        check("R4 old mask still used", {31'b0, wait_ready[0]}, 32'h0);
        step();
        mask_we = '0;
        wait_req = 4'b0011;
        #1;
        check("R5 stall core0", {31'b0, wait_ready[0]}, 32'h0);
        check("R5 stall data core0", wait_data[31:0], 32'h0);
        check("R4 core1 mask unchanged", {31'b0, wait_ready[1]}, 32'h0);

        // R2 and R6: a peer sets bit 5; core 0 releases the cycle after.
        set_we[2] = 1'b1;
        set_data[95:64] = 32'h0000_0020;
        #1;
        check("R2 not before edge", {31'b0, wait_ready[0]}, 32'h0);
        step();
        set_we = '0;
        #1;
        check("R6 release", {31'b0, wait_ready[0]}, 32'h1);
        check("R6 full word", wait_data[31:0], 32'hA500_0030);
        idle();
        step();

        // R10: the condition already holds, so the wait completes at once.
        wait_req[0] = 1'b1;
        #1;
        check("R10 no stall", {31'b0, wait_ready[0]}, 32'h1);
        check("R10 data", wait_data[31:0], 32'hA500_0030);
        idle();

        // Mask on a flag bit: a flag alone releases the wait (R1, R6).
        mask_we[3] = 1'b1;
        mask_data[127:96] = 32'h0100_0000;
        step();
        idle();
        wait_req[3] = 1'b1;
        fifo_flags = 8'h00;
        #1;
        check("R5 flag wait stalls", {31'b0, wait_ready[3]}, 32'h0);
        fifo_flags = 8'h01;
        #1;
        check("R6 flag release", wait_data[127:96], 32'h0100_0030);
        idle();
        step();

        // Random traffic, checked every cycle against the model.
        for (int i = 0; i < 3000; i++) begin
            fifo_flags = 8'($urandom);
            for (int c = 0; c < N; c++) begin
                set_we[c] = ($urandom % 4) == 0;
                clr_we[c] = ($urandom % 4) == 0;
                mask_we[c] = ($urandom % 8) == 0;
                wait_req[c] = ($urandom % 2) == 0;
                set_data[c*W +: W] = $urandom & $urandom & $urandom;
                clr_data[c*W +: W] = $urandom & $urandom;
                mask_data[c*W +: W] = $urandom & $urandom & $urandom;
            end
            if (i % 500 == 499) rst_n = 1'b0;
            else rst_n = 1'b1;
            #1;
            if (rst_n) check_all("rand R2 R3 R8");
            step();
        end
        rst_n = 1'b1;
        idle();
        #1;
        check_all("final R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule